// File: doc/BRIEF.md
# Inter-Packet Departure Pacer

This block sits in series on a 64-bit AXI4-Stream transmit path. It lets packets through but holds back the first beat of each packet until its slot comes up. Every packet carries a side-band delay, a count of clock cycles measured from that packet's first beat to the first beat of the packet after it. Beats inside a packet are never held by the pacer. An `active_i` input lets new packets start; while it is low, no new packet starts.

When the schedule cannot be met, a sticky warning flag is set. This happens when a packet is still on the wire at the moment its successor is due, either because the delay is shorter than the packet or because the receiver stalled the stream. In that case the next packet leaves on the cycle after the late packet's TLAST. A small AXI4-Lite register port returns the flag and accepts a clear command.

Top module: `ipg_pacer`

## Requirements
- R1: After hardware reset, the status register reads 0 and `m_axis_tvalid` stays low until `active_i` is raised.
- R2: While `active_i` is low, no new packet starts on the output. Once `active_i` is high, the pending packet starts without further delay.
- R3: If the delay G is at least the packet length L in beats and the stream is not stalled, consecutive first beats leave exactly G cycles apart.
- R4: If G equals L, packets leave back to back and the warning stays clear.
- R5: If G is less than L, the next packet starts on the cycle after the previous TLAST, and bit 0 of the status register (offset 0x0) becomes 1.
- R6: If TREADY backpressure keeps a packet on the wire past its successor's slot, the successor starts on the cycle after that TLAST and status bit 0 becomes 1.
- R7: The warning is sticky. Bits 31:1 of the status register always read 0.
- R8: A write to offset 0x4 with bit 0 set clears the warning and drops any pending slot. A write of 0 to offset 0x4, or any write to offset 0x0, leaves the warning unchanged.
- R9: Data, keep and last pass through unchanged and in order. Inside a packet, beats are limited only by the valid/ready handshake.
- R10: Every write gets a response with OKAY (0) on the cycle after the address/data handshake. Every read returns data with OKAY on the cycle after the address handshake, and that data is held while `cfg_rready` is low.
- R11: A delay of 0 behaves like a delay of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active_i | input | 1 | Allows new packets to start |
| s_axis_tdata | input | 64 | Input stream data |
| s_axis_tkeep | input | 8 | Input byte enables |
| s_axis_tlast | input | 1 | Input last beat of packet |
| s_axis_tvalid | input | 1 | Input valid |
| s_axis_tready | output | 1 | Input ready |
| s_axis_gap | input | 16 | Delay in cycles to the next packet start, read on the first beat |
| m_axis_tdata | output | 64 | Output stream data |
| m_axis_tkeep | output | 8 | Output byte enables |
| m_axis_tlast | output | 1 | Output last beat |
| m_axis_tvalid | output | 1 | Output valid |
| m_axis_tready | input | 1 | Output ready |
| cfg_awaddr | input | 4 | Write address |
| cfg_awvalid | input | 1 | Write address valid |
| cfg_awready | output | 1 | Write address ready |
| cfg_wdata | input | 32 | Write data |
| cfg_wvalid | input | 1 | Write data valid |
| cfg_wready | output | 1 | Write data ready |
| cfg_bresp | output | 2 | Write response |
| cfg_bvalid | output | 1 | Write response valid |
| cfg_bready | input | 1 | Write response ready |
| cfg_araddr | input | 4 | Read address |
| cfg_arvalid | input | 1 | Read address valid |
| cfg_arready | output | 1 | Read address ready |
| cfg_rdata | output | 32 | Read data |
| cfg_rresp | output | 2 | Read response |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rready | input | 1 | Read data ready |

## Verification
Stream beats pass through with no register delay, so each output handshake is sampled on the falling edge just before the rising edge at which it takes effect. Start-to-start spacing is then measured by counting rising edges between first beats, and the expected value is max(max(G,1), L), or a stall-extended length. The warning flag is registered in the same cycle as the missed slot, and register reads return data one cycle after the address handshake. Status is therefore read only after the stream has drained, and read data is sampled just after the rising edge that makes `cfg_rvalid` high.

// File: rtl/ipg_pacer_pkg.sv
package ipg_pacer_pkg;
  localparam int CSR_DW = 32;
  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam int OFS_STATUS = 0;
  localparam int OFS_CLEAR  = 4;
  localparam logic [CSR_DW-1:0] CLEAR_MASK = 32'h1;
endpackage

// File: rtl/ipg_slot_timer.sv
module ipg_slot_timer #(
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          start,
  input  logic [GW-1:0] gap,
  output logic          due,
  output logic          slot_now
);
  logic [GW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (start) begin
      pend_q <= 1'b1;
      cnt_q  <= (gap == '0) ? '0 : gap - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign slot_now = pend_q && (cnt_q == '0);
  assign due      = !pend_q || (cnt_q == '0);
endmodule

// File: rtl/ipg_stream_gate.sv
module ipg_stream_gate #(
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            due,
  input  logic            slot_now,
  input  logic [DW-1:0]   s_tdata,
  input  logic [DW/8-1:0] s_tkeep,
  input  logic            s_tlast,
  input  logic            s_tvalid,
  output logic            s_tready,
  output logic [DW-1:0]   m_tdata,
  output logic [DW/8-1:0] m_tkeep,
  output logic            m_tlast,
  output logic            m_tvalid,
  input  logic            m_tready,
  output logic            start,
  output logic            miss
);
  logic in_pkt_q;
  logic open_w;
  logic fire_w;

  assign open_w   = in_pkt_q || (active && due);
  assign m_tvalid = s_tvalid && open_w;
  assign s_tready = m_tready && open_w;
  assign m_tdata  = s_tdata;
  assign m_tkeep  = s_tkeep;
  assign m_tlast  = s_tlast;
  assign fire_w   = s_tvalid && s_tready;
  assign start    = fire_w && !in_pkt_q;
  assign miss     = active && slot_now && !start && (in_pkt_q || s_tvalid);

  always_ff @(posedge clk) begin
    if (rst)         in_pkt_q <= 1'b0;
    else if (fire_w) in_pkt_q <= !s_tlast;
  end
endmodule

// File: rtl/ipg_csr.sv
module ipg_csr
  import ipg_pacer_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss,
  output logic              clr,
  input  logic [AW-1:0]     awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [CSR_DW-1:0] wdata,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [AW-1:0]     araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [CSR_DW-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready
);
  logic warn_q;
  logic wr_fire, rd_fire;

  assign awready = awvalid && wvalid && !bvalid;
  assign wready  = awready;
  assign wr_fire = awready;
  assign arready = !rvalid;
  assign rd_fire = arvalid && arready;
  assign clr     = wr_fire && (awaddr == AW'(OFS_CLEAR)) && ((wdata & CLEAR_MASK) != '0);
  assign bresp   = RESP_OKAY;
  assign rresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_q <= 1'b0;
      bvalid <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      if (clr)       warn_q <= 1'b0;
      else if (miss) warn_q <= 1'b1;
      if (wr_fire)     bvalid <= 1'b1;
      else if (bready) bvalid <= 1'b0;
      if (rd_fire) begin
        rvalid <= 1'b1;
        rdata  <= (araddr == AW'(OFS_STATUS)) ? {{(CSR_DW-1){1'b0}}, warn_q} : '0;
      end else if (rready) begin
        rvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipg_pacer.sv
module ipg_pacer
  import ipg_pacer_pkg::*;
#(
  parameter int DW = 64,
  parameter int GW = 16,
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic [DW-1:0]     s_axis_tdata,
  input  logic [DW/8-1:0]   s_axis_tkeep,
  input  logic              s_axis_tlast,
  input  logic              s_axis_tvalid,
  output logic              s_axis_tready,
  input  logic [GW-1:0]     s_axis_gap,
  output logic [DW-1:0]     m_axis_tdata,
  output logic [DW/8-1:0]   m_axis_tkeep,
  output logic              m_axis_tlast,
  output logic              m_axis_tvalid,
  input  logic              m_axis_tready,
  input  logic [AW-1:0]     cfg_awaddr,
  input  logic              cfg_awvalid,
  output logic              cfg_awready,
  input  logic [CSR_DW-1:0] cfg_wdata,
  input  logic              cfg_wvalid,
  output logic              cfg_wready,
  output logic [1:0]        cfg_bresp,
  output logic              cfg_bvalid,
  input  logic              cfg_bready,
  input  logic [AW-1:0]     cfg_araddr,
  input  logic              cfg_arvalid,
  output logic              cfg_arready,
  output logic [CSR_DW-1:0] cfg_rdata,
  output logic [1:0]        cfg_rresp,
  output logic              cfg_rvalid,
  input  logic              cfg_rready
);
  logic sched_due, sched_slot, pkt_start, slot_miss, soft_clr;

  ipg_slot_timer #(.GW(GW)) u_timer (
    .clk(clk), .rst(rst), .clr(soft_clr), .start(pkt_start), .gap(s_axis_gap),
    .due(sched_due), .slot_now(sched_slot)
  );

  ipg_stream_gate #(.DW(DW)) u_gate (
    .clk(clk), .rst(rst), .active(active_i), .due(sched_due), .slot_now(sched_slot),
    .s_tdata(s_axis_tdata), .s_tkeep(s_axis_tkeep), .s_tlast(s_axis_tlast),
    .s_tvalid(s_axis_tvalid), .s_tready(s_axis_tready),
    .m_tdata(m_axis_tdata), .m_tkeep(m_axis_tkeep), .m_tlast(m_axis_tlast),
    .m_tvalid(m_axis_tvalid), .m_tready(m_axis_tready),
    .start(pkt_start), .miss(slot_miss)
  );

  ipg_csr #(.AW(AW)) u_csr (
    .clk(clk), .rst(rst), .miss(slot_miss), .clr(soft_clr),
    .awaddr(cfg_awaddr), .awvalid(cfg_awvalid), .awready(cfg_awready),
    .wdata(cfg_wdata), .wvalid(cfg_wvalid), .wready(cfg_wready),
    .bresp(cfg_bresp), .bvalid(cfg_bvalid), .bready(cfg_bready),
    .araddr(cfg_araddr), .arvalid(cfg_arvalid), .arready(cfg_arready),
    .rdata(cfg_rdata), .rresp(cfg_rresp), .rvalid(cfg_rvalid), .rready(cfg_rready)
  );
endmodule

// File: rtl/ipg_pacer_chk.sv
module ipg_pacer_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          active_i,
  input logic [DW-1:0] s_tdata,
  input logic          s_tvalid,
  input logic          s_tready,
  input logic [DW-1:0] m_tdata,
  input logic          m_tvalid,
  input logic          m_tready,
  input logic          m_tlast,
  input logic          sched_due,
  input logic          slot_miss,
  input logic          soft_clr,
  input logic          bvalid,
  input logic          bready,
  input logic          rvalid,
  input logic          rready,
  input logic [31:0]   rdata
);
  logic out_in_pkt;
  logic first_beat;

  always_ff @(posedge clk) begin
    if (rst) out_in_pkt <= 1'b0;
    else if (m_tvalid && m_tready) out_in_pkt <= !m_tlast;
  end
  assign first_beat = m_tvalid && m_tready && !out_in_pkt;

  // R2
  no_start_inactive_chk: assert property (@(posedge clk) disable iff (rst)
    first_beat |-> active_i);
  // R3
  start_on_slot_chk: assert property (@(posedge clk) disable iff (rst)
    first_beat |-> sched_due);
  // R9
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (s_tvalid && s_tready) |-> (m_tvalid && m_tready && (m_tdata == s_tdata)));
  // R7
  warn_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_miss && !soft_clr) |=> (!rvalid || rdata[31:1] == '0));
  // R10
  bresp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> bvalid);
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
endmodule

bind ipg_pacer ipg_pacer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .active_i(active_i),
  .s_tdata(s_axis_tdata), .s_tvalid(s_axis_tvalid), .s_tready(s_axis_tready),
  .m_tdata(m_axis_tdata), .m_tvalid(m_axis_tvalid), .m_tready(m_axis_tready),
  .m_tlast(m_axis_tlast), .sched_due(sched_due), .slot_miss(slot_miss),
  .soft_clr(soft_clr), .bvalid(cfg_bvalid), .bready(cfg_bready),
  .rvalid(cfg_rvalid), .rready(cfg_rready), .rdata(cfg_rdata)
);

// File: tb/ipg_pacer_test.sv
`timescale 1ns/1ps
module ipg_pacer_test;
  localparam int DW = 64;
  localparam int GW = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, active = 1'b0, mrdy = 1'b1;
  logic s_tready, m_tlast, m_tvalid;
  logic [DW-1:0] m_tdata;
  logic [DW/8-1:0] m_tkeep;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic [31:0] wdata = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;

  int vectors = 0, errors = 0, cyc = 0;
  int plen[8], pgap[8];
  int npk = 0, sp = 0, sb = 0, gb = 0;
  bit src_en = 1'b0;
  int ob = 0, mp = 0, mb = 0;
  int st[8];

  wire s_tvalid = src_en && (sp < npk);
  wire [DW-1:0] s_tdata = {32'hBEEF0000 | 32'(sp), 32'(gb)};
  wire s_tlast = (sp < npk) && (sb == plen[sp & 7] - 1);
  wire [GW-1:0] s_gap = GW'(pgap[sp & 7]);

  ipg_pacer #(.DW(DW), .GW(GW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .active_i(active),
    .s_axis_tdata(s_tdata), .s_axis_tkeep('1), .s_axis_tlast(s_tlast),
    .s_axis_tvalid(s_tvalid), .s_axis_tready(s_tready), .s_axis_gap(s_gap),
    .m_axis_tdata(m_tdata), .m_axis_tkeep(m_tkeep), .m_axis_tlast(m_tlast),
    .m_axis_tvalid(m_tvalid), .m_axis_tready(mrdy),
    .cfg_awaddr(awaddr), .cfg_awvalid(awvalid), .cfg_awready(awready),
    .cfg_wdata(wdata), .cfg_wvalid(wvalid), .cfg_wready(wready),
    .cfg_bresp(bresp), .cfg_bvalid(bvalid), .cfg_bready(1'b1),
    .cfg_araddr(araddr), .cfg_arvalid(arvalid), .cfg_arready(arready),
    .cfg_rdata(rdata), .cfg_rresp(rresp), .cfg_rvalid(rvalid), .cfg_rready(1'b1)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // source and monitor: sample before the edge, update after it
  initial forever begin
    bit sf, mf;
    logic [DW-1:0] d;
    logic l;
    @(negedge clk);
    sf = s_tvalid && s_tready;
    mf = m_tvalid && mrdy;
    d = m_tdata;
    l = m_tlast;
    if (mf) begin
      // R9: data in order, last marks packet end
      check(d[31:0] == 32'(ob), "R9 data", d[31:0], ob);
      check(l == (mb == plen[mp & 7] - 1), "R9 last", l, mb == plen[mp & 7] - 1);
      if (mb == 0) st[mp & 7] = cyc;
    end
    @(posedge clk);
    #1;
    cyc++;
    if (sf) begin
      gb++;
      if (sb == plen[sp & 7] - 1) begin sp++; sb = 0; end else sb++;
    end
    if (mf) begin
      ob++;
      if (mb == plen[mp & 7] - 1) begin mp++; mb = 0; end else mb++;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic csr_write(input int a, input int v);
    tick();
    awaddr = AW'(a); wdata = 32'(v); awvalid = 1'b1; wvalid = 1'b1;
    tick();
    awvalid = 1'b0; wvalid = 1'b0;
    // R10
    check(bvalid && bresp == 2'b00, "R10 bresp", {bvalid, bresp}, 4);
    tick();
  endtask

  task automatic csr_read(input int a, output logic [31:0] v);
    tick();
    araddr = AW'(a); arvalid = 1'b1;
    tick();
    arvalid = 1'b0;
    // R10
    check(rvalid && rresp == 2'b00, "R10 rresp", {rvalid, rresp}, 4);
    v = rdata;
    tick();
  endtask

  task automatic load(input int n, input int l, input int g);
    npk = n; sp = 0; sb = 0; gb = 0; ob = 0; mp = 0; mb = 0;
    for (int i = 0; i < 8; i++) begin plen[i] = l; pgap[i] = g; st[i] = 0; end
    src_en = 1'b1;
  endtask

  task automatic wait_done(input int n);
    for (int k = 0; k < 400 && mp < n; k++) tick();
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R1
    csr_read(0, v);
    check(v == 0, "R1 status", v, 0);
    check(!m_tvalid, "R1 tvalid", m_tvalid, 0);

    // R2: source waiting, active low
    tick();
    load(1, 2, 3);
    begin
      int seen = 0;
      for (int k = 0; k < 12; k++) begin tick(); if (m_tvalid) seen++; end
      check(seen == 0, "R2 hold", seen, 0);
    end
    active = 1'b1;
    wait_done(1);
    check(mp == 1, "R2 release", mp, 1);
    active = 1'b0;
    csr_write(4, 1);

    // R3 R4 R5 R11 sweep
    for (int l = 1; l <= 5; l++) begin
      for (int g = 0; g <= 7; g++) begin
        int eff, exp_d;
        bit exp_w;
        eff = (g == 0) ? 1 : g;
        exp_d = (eff >= l) ? eff : l;
        exp_w = (eff < l);
        tick();
        load(3, l, g);
        active = 1'b1;
        wait_done(3);
        active = 1'b0;
        check(mp == 3, "R3 count", mp, 3);
        if (g == 0)       begin check(st[1] - st[0] == exp_d, "R11 spacing", st[1] - st[0], exp_d); end
        else if (g >= l)  begin check(st[1] - st[0] == exp_d, "R3 spacing", st[1] - st[0], exp_d); end
        else              begin check(st[1] - st[0] == exp_d, "R5 spacing", st[1] - st[0], exp_d); end
        check(st[2] - st[1] == exp_d, (g == l) ? "R4 spacing" : "R3 spacing2", st[2] - st[1], exp_d);
        csr_read(0, v);
        if (g == l) check(v == 0, "R4 no warning", v, 0);
        else        check(v == 32'(exp_w), "R5 warning", v, exp_w);
        csr_write(4, 1);
        csr_read(0, v);
        check(v == 0, "R8 cleared", v, 0);
      end
    end

    // R6: backpressure delays last beat past the slot
    tick();
    load(2, 2, 4);
    active = 1'b1;
    for (int k = 0; k < 50 && ob < 1; k++) tick();
    mrdy = 1'b0;
    repeat (6) tick();
    mrdy = 1'b1;
    wait_done(2);
    active = 1'b0;
    check(st[1] - st[0] == 8, "R6 spacing", st[1] - st[0], 8);
    csr_read(0, v);
    check(v == 1, "R6 warning", v, 1);

    // R7 R8: stays set through other writes
    csr_write(4, 0);
    csr_write(0, 1);
    repeat (5) tick();
    csr_read(0, v);
    check(v == 1, "R7 sticky", v, 1);
    check(v[31:1] == 0, "R7 upper bits", v[31:1], 0);
    csr_write(4, 1);
    csr_read(0, v);
    check(v == 0, "R8 clear", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    vectors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule